// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Buffer

This block maps a 40-bit virtual byte address onto a 36-bit physical byte address. It holds recently used page mappings in a 256-entry cache organised as 128 sets of two ways. Pages are 16 KB. The low 14 address bits are the byte offset and are not translated. The next 7 bits select a set, and the top 19 bits form the tag that is compared against both ways of that set at the same time. The physical page number of the matching way is joined with the offset to form the physical address.

A lookup is combinational. It reports a hit, a miss, or a permission fault, where a fault means the page is mapped but the entry forbids the requested access. A separate refill port installs one mapping per cycle. The set comes from the refill page number. The way is picked by the block: an empty way is used first, otherwise the least recently used one. A flush input invalidates every entry in one cycle. Walking the page tables and handling faults are left to the surrounding logic. That logic reacts to a miss or a fault and then issues refills.

Top module: `tlb2w_xlate`

## Requirements
- R1: On a hit or a fault, `lk_paddr[13:0]` equals `lk_vaddr[13:0]` and `lk_paddr[35:14]` is the stored 22-bit physical page number. The set index is `lk_vaddr[20:14]` and the tag is `lk_vaddr[39:21]`. On refill, `rf_vpn[6:0]` is the set and `rf_vpn[25:7]` is the tag.
- R2: When a valid entry in the indexed set has a matching tag and permits the access, `lk_hit`=1 and `lk_fault`=0. `lk_write`=0 means a read and needs the stored read permit. `lk_write`=1 means a write and needs the stored write permit.
- R3: When no valid entry of the indexed set matches the tag, `lk_hit`=0, `lk_fault`=0 and `lk_paddr`=0. This includes every lookup after reset.
- R4: When a matching entry lacks the permit for the requested access, `lk_fault`=1 and `lk_hit`=0, and `lk_paddr` still carries the translation.
- R5: A refill writes an invalid way of its set if one exists, way 0 before way 1. It never overwrites a valid entry while the other way is empty.
- R6: When both ways of the set are valid, a refill replaces the way that was not most recently hit by a qualified lookup or written by a refill. A refill into a set overrides a same-cycle lookup hit in that set for this ordering.
- R7: A flush invalidates all 256 entries at the next clock edge, so every lookup in the following cycle misses. A refill presented in the same cycle as a flush is discarded. A lookup in the flush cycle still sees the old contents.
- R8: A lookup presented in the same cycle as a refill to the same set sees the contents from before the refill. The new entry is visible from the next cycle.
- R9: Entries in different sets are independent: an equal tag under a different set index does not match.
- R10: A lookup with `lk_valid`=0 still drives the outputs but does not change the replacement ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup qualifier; only qualified hits update replacement order |
| lk_vaddr | input | 40 | Virtual byte address to translate |
| lk_write | input | 1 | Access kind: 0 read, 1 write |
| lk_hit | output | 1 | Mapping found and access permitted |
| lk_fault | output | 1 | Mapping found but access not permitted |
| lk_paddr | output | 36 | Translated physical address, zero on miss |
| rf_valid | input | 1 | Install a mapping this cycle |
| rf_vpn | input | 26 | Virtual page number of the mapping |
| rf_ppn | input | 22 | Physical page number of the mapping |
| rf_rd_ok | input | 1 | Read permit of the mapping |
| rf_wr_ok | input | 1 | Write permit of the mapping |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest behaviour to reach from the ports is the replacement choice. The ordering bit is not visible, so it can only be inferred from which of two old mappings survives a third refill into a full set. The stimulus fills a set with two mappings and then touches one of them with a qualified lookup. In a second set it uses an unqualified lookup instead. It then refills a third page into each set and looks up all three pages to see which one was evicted. Same-cycle refill and lookup, and flush combined with refill, are driven in single cycles and checked in that cycle and the one after.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

  localparam int unsigned TLB_VA_W  = 40;
  localparam int unsigned TLB_OFS_W = 14;
  localparam int unsigned TLB_IDX_W = 7;
  localparam int unsigned TLB_PPN_W = 22;

  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;

  // Empty way first (way 0 before way 1), otherwise the replacement pointer.
  function automatic logic pick_victim(input logic vld0, input logic vld1,
                                       input logic lru_way);
    if (!vld0)      return 1'b0;
    else if (!vld1) return 1'b1;
    else            return lru_way;
  endfunction

endpackage

// File: rtl/tlb2w_way.sv
module tlb2w_way #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 19,
  parameter int unsigned PPN_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_match,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_rd_ok,
  output logic             rd_wr_ok,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_rd_ok,
  input  logic             wr_wr_ok,
  output logic             wr_slot_vld
);

  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  vld_d;
  logic             vld_en;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  logic [SETS-1:0]  rdok_q;
  logic [SETS-1:0]  wrok_q;

  // valid bits: flush beats a write
  always_comb begin
    vld_d  = vld_q;
    vld_en = flush | wr_en;
    if (flush)      vld_d = '0;
    else if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (vld_en) vld_q <= vld_d;
  end

  // payload storage, no reset, written only under enable
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx]  <= wr_tag;
      ppn_q[wr_idx]  <= wr_ppn;
      rdok_q[wr_idx] <= wr_rd_ok;
      wrok_q[wr_idx] <= wr_wr_ok;
    end
  end

  assign rd_match    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_ppn      = ppn_q[rd_idx];
  assign rd_rd_ok    = rdok_q[rd_idx];
  assign rd_wr_ok    = wrok_q[rd_idx];
  assign wr_slot_vld = vld_q[wr_idx];

endmodule

// File: rtl/tlb2w_lru.sv
module tlb2w_lru #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_way,
  output logic             fill_lru_way
);

  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;
  logic            lru_en;

  // pointer names the way not most recently used; a fill overrides a hit
  always_comb begin
    lru_d  = lru_q;
    lru_en = hit_en | fill_en;
    if (hit_en)  lru_d[hit_idx]  = ~hit_way;
    if (fill_en) lru_d[fill_idx] = ~fill_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q <= lru_d;
  end

  assign fill_lru_way = lru_q[fill_idx];

endmodule

// File: rtl/tlb2w_xlate.sv
module tlb2w_xlate
  import tlb2w_pkg::*;
#(
  parameter int unsigned VA_W  = TLB_VA_W,
  parameter int unsigned OFS_W = TLB_OFS_W,
  parameter int unsigned IDX_W = TLB_IDX_W,
  parameter int unsigned PPN_W = TLB_PPN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic                   lk_write,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  input  logic                   rf_valid,
  input  logic [VA_W-OFS_W-1:0]  rf_vpn,
  input  logic [PPN_W-1:0]       rf_ppn,
  input  logic                   rf_rd_ok,
  input  logic                   rf_wr_ok,
  input  logic                   flush
);

  localparam int unsigned VPN_W = VA_W - OFS_W;
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned NWAYS = 2;

  logic [OFS_W-1:0] lk_ofs;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] rf_idx;
  logic [TAG_W-1:0] rf_tag;
  acc_e             lk_acc;

  assign lk_ofs = lk_vaddr[OFS_W-1:0];
  assign lk_idx = lk_vaddr[OFS_W +: IDX_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign rf_idx = rf_vpn[IDX_W-1:0];
  assign rf_tag = rf_vpn[VPN_W-1 -: TAG_W];
  assign lk_acc = acc_e'(lk_write);

  logic [NWAYS-1:0] w_match;
  logic [NWAYS-1:0] w_rdok;
  logic [NWAYS-1:0] w_wrok;
  logic [NWAYS-1:0] w_slot_vld;
  logic [NWAYS-1:0] w_wr_en;
  logic [PPN_W-1:0] w_ppn [NWAYS];
  logic             fill_go;
  logic             victim;
  logic             lru_way;

  assign fill_go = rf_valid & ~flush;
  assign victim  = pick_victim(w_slot_vld[0], w_slot_vld[1], lru_way);

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    assign w_wr_en[g] = fill_go && (victim == 1'(g));

    tlb2w_way #(
      .IDX_W(IDX_W),
      .TAG_W(TAG_W),
      .PPN_W(PPN_W)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .rd_idx     (lk_idx),
      .rd_tag     (lk_tag),
      .rd_match   (w_match[g]),
      .rd_ppn     (w_ppn[g]),
      .rd_rd_ok   (w_rdok[g]),
      .rd_wr_ok   (w_wrok[g]),
      .wr_en      (w_wr_en[g]),
      .wr_idx     (rf_idx),
      .wr_tag     (rf_tag),
      .wr_ppn     (rf_ppn),
      .wr_rd_ok   (rf_rd_ok),
      .wr_wr_ok   (rf_wr_ok),
      .wr_slot_vld(w_slot_vld[g])
    );
  end

  // way-select mux driven by the compare results (way 0 has priority)
  logic             any_match;
  logic             sel_way;
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_ok;

  always_comb begin
    any_match = |w_match;
    sel_way   = ~w_match[0];
    sel_ppn   = sel_way ? w_ppn[1] : w_ppn[0];
    sel_ok    = (lk_acc == ACC_WR) ? w_wrok[sel_way] : w_rdok[sel_way];
    lk_hit    = any_match & sel_ok;
    lk_fault  = any_match & ~sel_ok;
    lk_paddr  = any_match ? {sel_ppn, lk_ofs} : '0;
  end

  tlb2w_lru #(
    .IDX_W(IDX_W)
  ) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_en      (lk_valid & lk_hit),
    .hit_idx     (lk_idx),
    .hit_way     (sel_way),
    .fill_en     (fill_go),
    .fill_idx    (rf_idx),
    .fill_way    (victim),
    .fill_lru_way(lru_way)
  );

endmodule

// File: rtl/tlb2w_xlate_chk.sv
module tlb2w_xlate_chk #(
  parameter int unsigned VA_W  = 40,
  parameter int unsigned OFS_W = 14,
  parameter int unsigned PPN_W = 22
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [VA_W-1:0]        lk_vaddr,
  input logic                   lk_hit,
  input logic                   lk_fault,
  input logic [PPN_W+OFS_W-1:0] lk_paddr,
  input logic                   rf_valid,
  input logic [VA_W-OFS_W-1:0]  rf_vpn,
  input logic                   flush
);

  // R2 / R4: hit and fault never together
  a_r2_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  a_r3_miss_paddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit || lk_fault) |-> (lk_paddr == '0));

  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_fault) |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(lk_hit || lk_fault));

  a_r8_refill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rf_valid && !flush) && (lk_vaddr[VA_W-1:OFS_W] == $past(rf_vpn)))
      |-> (lk_hit || lk_fault));

endmodule

bind tlb2w_xlate tlb2w_xlate_chk #(
  .VA_W (VA_W),
  .OFS_W(OFS_W),
  .PPN_W(PPN_W)
) u_chk (.*);

// File: tb/tlb2w_xlate_bench.sv
module tlb2w_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [39:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_hit;
  logic        lk_fault;
  logic [35:0] lk_paddr;
  logic        rf_valid = 1'b0;
  logic [25:0] rf_vpn = '0;
  logic [21:0] rf_ppn = '0;
  logic        rf_rd_ok = 1'b0;
  logic        rf_wr_ok = 1'b0;
  logic        flush = 1'b0;

  always #5 clk = ~clk;

  tlb2w_xlate u_tlb2w_xlate (.*);

  typedef struct {
    logic        hit;
    logic        fault;
    logic [35:0] pa;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference contents, built from the requirements
  logic        mv   [2][128];
  logic [18:0] mtag [2][128];
  logic [21:0] mppn [2][128];
  logic        mrd  [2][128];
  logic        mwr  [2][128];
  logic        mlru [128];

  function automatic logic [39:0] va(input logic [18:0] t, input logic [6:0] s,
                                     input logic [13:0] o);
    return {t, s, o};
  endfunction

  task automatic step(input logic lv, input logic [39:0] a, input logic wr,
                      input logic rv, input logic [25:0] rvpn, input logic [21:0] rppn,
                      input logic rr, input logic rw, input logic fl, input string req);
    logic [6:0]  s;
    logic [18:0] t;
    logic        m0, m1, w, ok, vw;
    logic [6:0]  ri;
    exp_t        e;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = a; lk_write = wr;
    rf_valid = rv; rf_vpn = rvpn; rf_ppn = rppn; rf_rd_ok = rr; rf_wr_ok = rw;
    flush = fl;
    s  = a[20:14];
    t  = a[39:21];
    m0 = mv[0][s] && (mtag[0][s] == t);
    m1 = mv[1][s] && (mtag[1][s] == t);
    w  = m0 ? 1'b0 : 1'b1;
    ok = wr ? mwr[w][s] : mrd[w][s];
    e.hit   = (m0 | m1) & ok;
    e.fault = (m0 | m1) & ~ok;
    e.pa    = (m0 | m1) ? {mppn[w][s], a[13:0]} : 36'd0;
    e.req   = req;
    if (lv) q.push_back(e);
    if (lv && e.hit) mlru[s] = ~w;
    if (fl) begin
      for (int k = 0; k < 128; k++) begin mv[0][k] = 1'b0; mv[1][k] = 1'b0; end
    end else if (rv) begin
      ri = rvpn[6:0];
      vw = !mv[0][ri] ? 1'b0 : (!mv[1][ri] ? 1'b1 : mlru[ri]);
      mv[vw][ri] = 1'b1; mtag[vw][ri] = rvpn[25:7]; mppn[vw][ri] = rppn;
      mrd[vw][ri] = rr; mwr[vw][ri] = rw; mlru[ri] = ~vw;
    end
  endtask

  task automatic look(input logic [39:0] a, input logic wr, input string req);
    step(1'b1, a, wr, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic fill(input logic [18:0] t, input logic [6:0] s, input logic [21:0] p,
                      input logic rr, input logic rw);
    step(1'b0, '0, 1'b0, 1'b1, {t, s}, p, rr, rw, 1'b0, "fill");
  endtask

  // monitor: compares each queued expectation against the outputs
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_run++;
        if (lk_hit !== e.hit || lk_fault !== e.fault || lk_paddr !== e.pa) begin
          n_fail++;
          $display("FAIL %s: got hit=%b fault=%b pa=%h, expected hit=%b fault=%b pa=%h",
                   e.req, lk_hit, lk_fault, lk_paddr, e.hit, e.fault, e.pa);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 128; k++) begin mv[0][k] = 1'b0; mv[1][k] = 1'b0; mlru[k] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    look(va(19'h0_1234, 7'd3, 14'h0AA), 1'b0, "R3 reset miss");
    fill(19'h1_2345, 7'd3, 22'h2A_BCDE, 1'b1, 1'b1);
    look(va(19'h1_2345, 7'd3, 14'h01A5), 1'b0, "R2 read hit");
    look(va(19'h1_2345, 7'd3, 14'h3001), 1'b1, "R1 write hit paddr");
    look(va(19'h1_2345, 7'd4, 14'h0001), 1'b0, "R9 other set miss");
    look(va(19'h1_2344, 7'd3, 14'h0001), 1'b0, "R3 tag mismatch");

    fill(19'h0_0007, 7'd10, 22'h00_1111, 1'b1, 1'b0);
    fill(19'h0_0008, 7'd11, 22'h00_2222, 1'b0, 1'b1);
    look(va(19'h0_0007, 7'd10, 14'h0123), 1'b1, "R4 write fault");
    look(va(19'h0_0007, 7'd10, 14'h0123), 1'b0, "R2 read permitted");
    look(va(19'h0_0008, 7'd11, 14'h0fed), 1'b0, "R4 read fault");
    look(va(19'h0_0008, 7'd11, 14'h0fed), 1'b1, "R2 write permitted");

    // R5 / R6 in set 5
    fill(19'h0_00A0, 7'd5, 22'h0A_0000, 1'b1, 1'b1);
    fill(19'h0_00B0, 7'd5, 22'h0B_0000, 1'b1, 1'b1);
    look(va(19'h0_00A0, 7'd5, 14'h10), 1'b0, "R5 first kept");
    look(va(19'h0_00B0, 7'd5, 14'h20), 1'b0, "R5 second placed");
    look(va(19'h0_00A0, 7'd5, 14'h30), 1'b0, "R6 touch first");
    fill(19'h0_00C0, 7'd5, 22'h0C_0000, 1'b1, 1'b1);
    look(va(19'h0_00A0, 7'd5, 14'h40), 1'b0, "R6 recent survives");
    look(va(19'h0_00B0, 7'd5, 14'h50), 1'b0, "R6 lru evicted");
    look(va(19'h0_00C0, 7'd5, 14'h60), 1'b0, "R6 new present");

    // R10 in set 9
    fill(19'h0_0A00, 7'd9, 22'h1A_0000, 1'b1, 1'b1);
    fill(19'h0_0B00, 7'd9, 22'h1B_0000, 1'b1, 1'b1);
    step(1'b0, va(19'h0_0A00, 7'd9, 14'h0), 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "R10 idle");
    fill(19'h0_0C00, 7'd9, 22'h1C_0000, 1'b1, 1'b1);
    look(va(19'h0_0A00, 7'd9, 14'h1), 1'b0, "R10 unqualified no touch");
    look(va(19'h0_0B00, 7'd9, 14'h2), 1'b0, "R10 other survives");

    // R8 same-cycle refill and lookup
    step(1'b1, va(19'h0_0D00, 7'd20, 14'h5), 1'b0, 1'b1, {19'h0_0D00, 7'd20}, 22'h3D_0000,
         1'b1, 1'b1, 1'b0, "R8 pre-refill miss");
    look(va(19'h0_0D00, 7'd20, 14'h6), 1'b0, "R8 visible next");

    // R7 flush with a refill in the same cycle
    step(1'b1, va(19'h1_2345, 7'd3, 14'h7), 1'b0, 1'b1, {19'h0_0E00, 7'd30}, 22'h3E_0000,
         1'b1, 1'b1, 1'b1, "R7 flush-cycle old view");
    look(va(19'h1_2345, 7'd3, 14'h8), 1'b0, "R7 cleared");
    look(va(19'h0_0E00, 7'd30, 14'h9), 1'b0, "R7 refill dropped");
    look(va(19'h0_00C0, 7'd5, 14'hA), 1'b0, "R7 set5 cleared");

    // R5 after flush and R1 at the extreme
    fill(19'h7_FFFF, 7'd127, 22'h3F_FFFF, 1'b1, 1'b1);
    fill(19'h0_0001, 7'd127, 22'h00_0001, 1'b1, 1'b1);
    look(va(19'h7_FFFF, 7'd127, 14'h3FFF), 1'b1, "R1 top address");
    look(va(19'h0_0001, 7'd127, 14'h0000), 1'b0, "R5 empty way used");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule